// File: doc/BRIEF.md
# Privilege-Aware Address Translation Selector

This block sits between a core's memory pipeline and its memory system. Each fetch, load or store request arrives with its access type. The block also samples the privilege and translation control fields: current privilege, previous privilege, a load/store privilege-swap enable, and the virtual-memory mode. From these it settles the privilege level the access runs at.

At machine level the address passes straight through, cut to the configured register width. At any lower level the block asks an external page-table walker for the page base on a separate request/response pair, then joins that base with the 12-bit page offset.

The physical address is then classified. Below the memory size it goes to main memory. Above it, a load or store is offered to a memory-mapped I/O port, and a fetch faults at once. A declined I/O access becomes a load or store access fault. Every fault reports the original virtual address. The block handles one request at a time and answers with a single-cycle response pulse.

Top module: `xlat_sel`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid, walk_req_valid and io_req_valid are 0. Whenever no request is in flight the block stays in this state.
- R2: The effective privilege (user=0, supervisor=1, machine=3) starts as cur_priv. For loads (req_kind=1) and stores (req_kind=2), a set ldst_prev_priv_en replaces it with prev_priv. For fetches (req_kind=0) that bit has no effect.
- R3: When vm_mode equals 0 (bare), the effective privilege is machine, whatever the other fields say.
- R4: At machine privilege no walk is requested. The physical address is req_vaddr with every bit at or above XLEN cleared.
- R5: At any other privilege, walk_req_valid rises with walk_req_vaddr equal to the request address. walk_req_sup is 1 exactly when the effective privilege is not user. The request holds steady until walk_req_ready.
- R6: After a walk, the physical address is walk_rsp_base ORed with bits 11:0 of the virtual address.
- R7: A physical address below MEM_BYTES gives a response with rsp_dest=0 (memory), rsp_fault=0 and rsp_addr equal to the physical address.
- R8: For a load or store at or above MEM_BYTES, io_req_valid rises. It carries io_req_addr equal to the physical address and io_req_write=1 for stores. If io_rsp_ok is 1, the response has rsp_dest=1 (I/O), rsp_fault=0 and the physical address.
- R9: If the I/O port declines, rsp_fault is 2 for a load or 3 for a store, and rsp_addr is the original virtual address.
- R10: A fetch at or above MEM_BYTES responds with rsp_fault=1 and rsp_addr equal to the virtual address, and never raises io_req_valid.
- R11: rsp_valid lasts exactly one cycle, and req_ready is 1 on the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and accepting |
| req_vaddr | input | ADDR_W | Virtual address |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| cur_priv | input | 2 | Current privilege |
| prev_priv | input | 2 | Previous privilege |
| ldst_prev_priv_en | input | 1 | Loads/stores use prev_priv |
| vm_mode | input | VM_W | Translation mode, 0 = bare |
| walk_req_valid | output | 1 | Walk requested |
| walk_req_ready | input | 1 | Walker accepts |
| walk_req_vaddr | output | ADDR_W | Address to walk |
| walk_req_sup | output | 1 | Walk at supervisor level |
| walk_rsp_valid | input | 1 | Walk result present |
| walk_rsp_base | input | ADDR_W | Page base from walker |
| io_req_valid | output | 1 | I/O access offered |
| io_req_addr | output | ADDR_W | Physical address for I/O |
| io_req_write | output | 1 | I/O access is a store |
| io_rsp_valid | input | 1 | I/O port answers |
| io_rsp_ok | input | 1 | I/O port claimed the access |
| rsp_valid | output | 1 | Result pulse |
| rsp_addr | output | ADDR_W | Physical address, or virtual address on fault |
| rsp_dest | output | 1 | 0 memory, 1 I/O |
| rsp_fault | output | 2 | 0 none, 1 fetch, 2 load, 3 store fault |

## Verification
The bench aims at the privilege-swap asymmetry. A design that applied the swap to fetches would walk a machine-level fetch, and one that skipped the bare-mode override would walk a supervisor load. It probes the memory-size boundary from both sides. An off-by-one there would send the last word to I/O or route the first I/O address to memory. It feeds addresses with bits above XLEN set, which an unmasked pass-through would carry into the result. It also checks that declined I/O and out-of-range fetches report the virtual address, which a careless design would replace with the translated one. Walker stalls of several cycles test that the walk request stays put.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam logic [1:0] ACC_FETCH = 2'd0;
    localparam logic [1:0] ACC_LOAD  = 2'd1;
    localparam logic [1:0] ACC_STORE = 2'd2;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam logic [1:0] FLT_NONE  = 2'd0;
    localparam logic [1:0] FLT_FETCH = 2'd1;
    localparam logic [1:0] FLT_LOAD  = 2'd2;
    localparam logic [1:0] FLT_STORE = 2'd3;

    localparam int PG_OFF_W = 12;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WALK_REQ, ST_WALK_WAIT, ST_ROUTE, ST_IO, ST_RESP
    } st_e;
endpackage

// File: rtl/xlat_priv_sel.sv
module xlat_priv_sel
    import xlat_pkg::*;
#(
    parameter int VM_W = 4,
    parameter logic [VM_W-1:0] VM_BARE = '0
) (
    input  logic [1:0]      kind,
    input  logic [1:0]      cur,
    input  logic [1:0]      prev,
    input  logic            swap_en,
    input  logic [VM_W-1:0] vm,
    output logic [1:0]      eff
);
    always_comb begin
        eff = cur;
        if (kind != ACC_FETCH && swap_en) eff = prev;
        if (vm == VM_BARE) eff = PRIV_M;
    end
endmodule

// File: rtl/xlat_addr_form.sv
module xlat_addr_form
    import xlat_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int XLEN   = 32
) (
    input  logic [ADDR_W-1:0] in_va,
    input  logic [ADDR_W-1:0] held_va,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] mach_pa,
    output logic [ADDR_W-1:0] walk_pa
);
    generate
        if (XLEN >= ADDR_W) begin : g_full
            assign mach_pa = in_va;
        end else begin : g_cut
            assign mach_pa = {{(ADDR_W-XLEN){1'b0}}, in_va[XLEN-1:0]};
        end
    endgenerate

    assign walk_pa = base | {{(ADDR_W-PG_OFF_W){1'b0}}, held_va[PG_OFF_W-1:0]};
endmodule

// File: rtl/xlat_route.sv
module xlat_route
    import xlat_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter logic [ADDR_W-1:0] MEM_BYTES = 40'h00_8000_0000
) (
    input  logic [ADDR_W-1:0] pa,
    input  logic [1:0]        kind,
    output logic              to_mem,
    output logic              to_io,
    output logic [1:0]        fault
);
    always_comb begin
        to_mem = pa < MEM_BYTES;
        to_io  = !to_mem && kind != ACC_FETCH;
        fault  = (!to_mem && kind == ACC_FETCH) ? FLT_FETCH : FLT_NONE;
    end
endmodule

// File: rtl/xlat_sel.sv
module xlat_sel
    import xlat_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int XLEN   = 32,
    parameter int VM_W   = 4,
    parameter logic [ADDR_W-1:0] MEM_BYTES = 40'h00_8000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [1:0]        req_kind,
    input  logic [1:0]        cur_priv,
    input  logic [1:0]        prev_priv,
    input  logic              ldst_prev_priv_en,
    input  logic [VM_W-1:0]   vm_mode,
    output logic              walk_req_valid,
    input  logic              walk_req_ready,
    output logic [ADDR_W-1:0] walk_req_vaddr,
    output logic              walk_req_sup,
    input  logic              walk_rsp_valid,
    input  logic [ADDR_W-1:0] walk_rsp_base,
    output logic              io_req_valid,
    output logic [ADDR_W-1:0] io_req_addr,
    output logic              io_req_write,
    input  logic              io_rsp_valid,
    input  logic              io_rsp_ok,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_dest,
    output logic [1:0]        rsp_fault
);
    typedef struct packed {
        st_e               st;
        logic [ADDR_W-1:0] va;
        logic [ADDR_W-1:0] pa;
        logic [1:0]        kind;
        logic [1:0]        priv;
        logic [1:0]        flt;
        logic              dest;
    } ctx_t;

    ctx_t s_q, s_d;

    logic [1:0]        eff_priv;
    logic [ADDR_W-1:0] mach_pa, walk_pa;
    logic              to_mem, to_io;
    logic [1:0]        route_flt;

    xlat_priv_sel #(.VM_W(VM_W)) u_priv (
        .kind(req_kind), .cur(cur_priv), .prev(prev_priv),
        .swap_en(ldst_prev_priv_en), .vm(vm_mode), .eff(eff_priv)
    );

    xlat_addr_form #(.ADDR_W(ADDR_W), .XLEN(XLEN)) u_addr (
        .in_va(req_vaddr), .held_va(s_q.va), .base(walk_rsp_base),
        .mach_pa(mach_pa), .walk_pa(walk_pa)
    );

    xlat_route #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) u_route (
        .pa(s_q.pa), .kind(s_q.kind), .to_mem(to_mem), .to_io(to_io),
        .fault(route_flt)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: if (req_valid) begin
                s_d.va   = req_vaddr;
                s_d.kind = req_kind;
                s_d.priv = eff_priv;
                s_d.dest = 1'b0;
                s_d.flt  = FLT_NONE;
                if (eff_priv == PRIV_M) begin
                    s_d.pa = mach_pa;
                    s_d.st = ST_ROUTE;
                end else begin
                    s_d.st = ST_WALK_REQ;
                end
            end
            ST_WALK_REQ:  if (walk_req_ready) s_d.st = ST_WALK_WAIT;
            ST_WALK_WAIT: if (walk_rsp_valid) begin
                s_d.pa = walk_pa;
                s_d.st = ST_ROUTE;
            end
            ST_ROUTE: begin
                if (to_io) begin
                    s_d.st = ST_IO;
                end else begin
                    s_d.flt = route_flt;
                    s_d.st  = ST_RESP;
                end
            end
            ST_IO: if (io_rsp_valid) begin
                if (io_rsp_ok) begin
                    s_d.dest = 1'b1;
                    s_d.flt  = FLT_NONE;
                end else begin
                    s_d.flt = (s_q.kind == ACC_STORE) ? FLT_STORE : FLT_LOAD;
                end
                s_d.st = ST_RESP;
            end
            ST_RESP: s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, va: '0, pa: '0, kind: '0, priv: '0, flt: '0, dest: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready      = s_q.st == ST_IDLE;
    assign walk_req_valid = s_q.st == ST_WALK_REQ;
    assign walk_req_vaddr = s_q.va;
    assign walk_req_sup   = s_q.priv != PRIV_U;
    assign io_req_valid   = s_q.st == ST_IO;
    assign io_req_addr    = s_q.pa;
    assign io_req_write   = s_q.kind == ACC_STORE;
    assign rsp_valid      = s_q.st == ST_RESP;
    assign rsp_addr       = (s_q.flt == FLT_NONE) ? s_q.pa : s_q.va;
    assign rsp_dest       = s_q.dest;
    assign rsp_fault      = s_q.flt;

    // R4
    mach_no_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && eff_priv == PRIV_M) |=> !walk_req_valid);
    // R5
    walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && !walk_req_ready) |=> (walk_req_valid && $stable(walk_req_vaddr)));
    // R7
    mem_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_NONE && !rsp_dest) |-> (rsp_addr < MEM_BYTES));
    // R10
    fetch_no_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_req_valid |-> !(io_req_write == 1'b0 && s_q.kind == ACC_FETCH));
    // R11
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));
endmodule

// File: tb/tb_xlat_sel.sv
module tb_xlat_sel;
    localparam int AW = 40;
    localparam logic [AW-1:0] MEM = 40'h00_8000_0000;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_ready;
    logic [AW-1:0] req_vaddr = '0;
    logic [1:0] req_kind = 0, cur_priv = 0, prev_priv = 0;
    logic ldst_prev_priv_en = 0;
    logic [3:0] vm_mode = 0;
    logic walk_req_valid, walk_req_ready = 0, walk_req_sup;
    logic [AW-1:0] walk_req_vaddr, walk_rsp_base = '0;
    logic walk_rsp_valid = 0;
    logic io_req_valid, io_req_write, io_rsp_valid = 0, io_rsp_ok = 0;
    logic [AW-1:0] io_req_addr;
    logic rsp_valid, rsp_dest;
    logic [AW-1:0] rsp_addr;
    logic [1:0] rsp_fault;

    int compared = 0, mismatched = 0;
    bit busy = 1, finished = 0;

    always #4 clk = ~clk;

    xlat_sel dut (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // idle monitor: every clock with no request in flight (R1)
    always @(negedge clk) if (rst_n && !busy && !finished) begin
        check("R1 ready", {63'd0, req_ready}, 64'd1);
        check("R1 quiet", {61'd0, rsp_valid, walk_req_valid, io_req_valid}, 64'd0);
    end

    task automatic run(input string tag, input logic [AW-1:0] va, input logic [1:0] kind,
                       input logic [1:0] cur, input logic [1:0] prev, input logic sw,
                       input logic [3:0] vm, input logic [AW-1:0] base, input logic ok,
                       input int wdly);
        int eff;
        bit exp_walk, exp_io, got, wdone, iodone, wpend;
        logic [AW-1:0] pa, exp_addr;
        logic [1:0] exp_flt;
        logic exp_dest;
        int wcnt;
        eff = cur;
        if (kind != 0 && sw) eff = prev;
        if (vm == 0) eff = 3;
        exp_walk = (eff != 3);
        pa = exp_walk ? (base | {28'd0, va[11:0]}) : {8'd0, va[31:0]};
        exp_io = 0; exp_dest = 0; exp_flt = 0; exp_addr = pa;
        if (pa >= MEM) begin
            if (kind == 0) begin exp_flt = 1; exp_addr = va; end
            else begin
                exp_io = 1;
                if (ok) exp_dest = 1;
                else begin exp_flt = (kind == 2) ? 3 : 2; exp_addr = va; end
            end
        end
        busy = 1;
        req_valid = 1; req_vaddr = va; req_kind = kind; cur_priv = cur;
        prev_priv = prev; ldst_prev_priv_en = sw; vm_mode = vm;
        check({tag, " R11 ready"}, {63'd0, req_ready}, 64'd1);
        @(negedge clk);
        req_valid = 0;
        got = 0; wdone = 0; iodone = 0; wpend = 0; wcnt = 0;
        for (int c = 0; c < 40 && !got; c++) begin
            walk_req_ready = 0; walk_rsp_valid = 0; io_rsp_valid = 0;
            if (wpend) begin walk_rsp_valid = 1; walk_rsp_base = base; wpend = 0; end
            if (walk_req_valid && !wdone) begin
                if (wcnt == 0) begin
                    check({tag, " R4/R5 walk expected"}, {63'd0, exp_walk}, 64'd1);
                    check({tag, " R5 sup"}, {63'd0, walk_req_sup}, {63'd0, eff != 0});
                end
                check({tag, " R5 walk vaddr"}, {24'd0, walk_req_vaddr}, {24'd0, va});
                wcnt++;
                if (wcnt > wdly) begin walk_req_ready = 1; wdone = 1; wpend = 1; end
            end
            if (io_req_valid && !iodone) begin
                check({tag, " R8/R10 io expected"}, {63'd0, exp_io}, 64'd1);
                check({tag, " R8 io addr"}, {24'd0, io_req_addr}, {24'd0, pa});
                check({tag, " R8 io write"}, {63'd0, io_req_write}, {63'd0, kind == 2});
                io_rsp_valid = 1; io_rsp_ok = ok; iodone = 1;
            end
            if (rsp_valid) begin
                got = 1;
                check({tag, " R7/R9/R10 fault"}, {62'd0, rsp_fault}, {62'd0, exp_flt});
                check({tag, " R6/R7/R8 addr"}, {24'd0, rsp_addr}, {24'd0, exp_addr});
                check({tag, " R7/R8 dest"}, {63'd0, rsp_dest}, {63'd0, exp_dest});
                check({tag, " R2/R3/R4 walk seen"}, {63'd0, wdone}, {63'd0, exp_walk});
                check({tag, " R9/R10 io seen"}, {63'd0, iodone}, {63'd0, exp_io});
            end
            @(negedge clk);
        end
        walk_req_ready = 0; walk_rsp_valid = 0; io_rsp_valid = 0;
        if (!got) check({tag, " R11 no response"}, 64'd0, 64'd1);
        check({tag, " R11 pulse"}, {62'd0, rsp_valid, req_ready}, 64'd1);
        busy = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        check("R1 reset ready", {63'd0, req_ready}, 64'd1);
        check("R1 reset quiet", {61'd0, rsp_valid, walk_req_valid, io_req_valid}, 64'd0);
        busy = 0;
        @(negedge clk);
        run("t1 R7",  40'h00_0000_1000, 0, 3, 0, 0, 4'd8, '0, 0, 0);
        run("t2 R4",  40'hAB_0000_1234, 1, 3, 0, 0, 4'd8, '0, 0, 0);
        run("t3 R2",  40'h00_0000_2000, 0, 3, 0, 1, 4'd8, '0, 0, 0);
        run("t4 R2",  40'h12_3456_7ABC, 1, 3, 0, 1, 4'd8, 40'h00_0004_5000, 0, 2);
        run("t5 R5",  40'h00_0000_0777, 2, 0, 1, 1, 4'd8, 40'h00_0000_3000, 0, 0);
        run("t6 R3",  40'hFF_1234_5678, 1, 1, 0, 0, 4'd0, '0, 0, 0);
        run("t7 R6",  40'h05_5555_5FFF, 0, 0, 0, 1, 4'd8, 40'h00_0100_0000, 0, 3);
        run("t8 R8",  40'h00_9000_0010, 1, 3, 0, 0, 4'd8, '0, 1, 0);
        run("t9 R9",  40'h00_FFFF_FFF0, 2, 3, 0, 0, 4'd8, '0, 0, 0);
        run("t10 R9", 40'h00_0000_0ABC, 1, 1, 0, 0, 4'd8, 40'hF0_0000_0000, 0, 1);
        run("t11 R10", 40'h01_8000_0000, 0, 3, 0, 0, 4'd8, '0, 1, 0);
        run("t12 R7", 40'h00_7FFF_FFFC, 1, 3, 0, 0, 4'd8, '0, 0, 0);
        run("t13 R10", 40'h00_0000_0010, 0, 1, 0, 0, 4'd8, 40'h00_8000_0000, 1, 0);
        run("t14 R2", 40'h3F_8000_0004, 2, 0, 3, 1, 4'd8, '0, 1, 0);
        run("t15 R8", 40'h00_0000_0124, 2, 1, 0, 0, 4'd8, 40'h00_A000_0000, 1, 0);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            finished = 1;
            compared++; mismatched++;
            $display("FAIL R11 watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule